// File: doc/BRIEF.md
# Instruction Timing Pulse Sequencer

This block produces the timing framework for a processor whose memory cycle is cut into twelve equal steps. It runs from a clock at twice the step rate. From that clock it makes two phase strobes that take turns and never coincide. The first phase moves a sixteen-state machine forward. The second phase goes out to the datapath as the strobe at which registers capture data. Control settles between the two phases.

Twelve of the states are the timing pulses of a memory cycle, shown one-hot on `tp`. Two states hold the machine in standby and bring it back up through a power-on step. The last two states let an operator advance the machine one pulse per press of a front-panel button. The current state code is also brought out, so test equipment can watch the machine as it moves.

Top module: `tpg_sequencer`

## Requirements
- R1: `ph1` and `ph2` are never high in the same `clk` cycle. Both are low while `rst_n` is low. After reset they alternate: `ph1` is high in the first cycle, then `ph2`, then `ph1`, and so on.
- R2: `state` changes only at a `clk` edge in whose preceding cycle `ph1` was high. It holds its value across every edge that closes a `ph2` cycle.
- R3: State codes. Pulses 1 to 12 are 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1001 and 1000. Standby is 1111 and power-on is 1110. The step-wait state is 1010 and the step-release state is 1011. The pulse codes change in exactly one bit from each pulse to the next, and from pulse 12 back to pulse 1.
- R4: `tp` is one-hot in a pulse state, with bit k-1 high for pulse k. It is all zero in the other four states. `busy` is high exactly when `tp` is non-zero.
- R5: Reset places the machine in standby. Standby is held for as long as `stby_req` is high. When `stby_req` is low, standby moves to power-on, and power-on moves to pulse 1 on the next advance.
- R6: With `step_mode` low, each advance moves from pulse k to pulse k+1. From pulse 12 the machine wraps to pulse 1.
- R7: A high `stby_req` does not cut a cycle short. Pulses up to pulse 12 still follow in order, and the advance after pulse 12 goes to standby instead of pulse 1.
- R8: With `step_mode` high, the advance out of a pulse goes to step-wait. Step-wait is held while `step_btn` is low and goes to step-release when the button is high. Step-release is held while the button is high. On release the machine goes to the next pulse, so one press moves exactly one pulse.
- R9: If `step_mode` is low during step-wait, the next advance goes straight to the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pulse rate |
| rst_n | input | 1 | Synchronous reset, active low |
| stby_req | input | 1 | Request to enter or stay in standby |
| step_mode | input | 1 | High selects one pulse per button press |
| step_btn | input | 1 | Front-panel step button, high while pressed |
| ph1 | output | 1 | Advance phase strobe |
| ph2 | output | 1 | Register capture phase strobe |
| tp | output | 12 | One-hot timing pulse vector |
| state | output | 4 | Current state code |
| busy | output | 1 | High while a timing pulse is active |

## Verification
The assertions assume that `stby_req`, `step_mode` and `step_btn` are already synchronous to `clk` and free of bounce. A press is taken to be a clean level that lasts across at least one advance. The bench changes every input only at the falling edge of `clk`. It holds each button level for several advances, so every transition it makes is one that a debounced, synchronised front-panel input could produce.

// File: rtl/tpg_sequencer.sv
module tpg_sequencer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stby_req,
  input  logic        step_mode,
  input  logic        step_btn,
  output logic        ph1,
  output logic        ph2,
  output logic [11:0] tp,
  output logic [3:0]  state,
  output logic        busy
);
  localparam int NPULSE = 12;
  localparam logic [3:0] LAST  = 4'(NPULSE - 1);
  localparam logic [3:0] S_STBY = 4'b1111;
  localparam logic [3:0] S_PWR  = 4'b1110;
  localparam logic [3:0] S_WAIT = 4'b1010;
  localparam logic [3:0] S_RLSE = 4'b1011;

  function automatic logic [3:0] pulse_code(input logic [3:0] idx);
    case (idx)
      4'd0:  pulse_code = 4'b0000;
      4'd1:  pulse_code = 4'b0001;
      4'd2:  pulse_code = 4'b0011;
      4'd3:  pulse_code = 4'b0010;
      4'd4:  pulse_code = 4'b0110;
      4'd5:  pulse_code = 4'b0111;
      4'd6:  pulse_code = 4'b0101;
      4'd7:  pulse_code = 4'b0100;
      4'd8:  pulse_code = 4'b1100;
      4'd9:  pulse_code = 4'b1101;
      4'd10: pulse_code = 4'b1001;
      default: pulse_code = 4'b1000;
    endcase
  endfunction

  logic [1:0] phase;
  logic [3:0] cur, nxt_state, nxt_cur, succ_state, succ_cur;
  logic       in_tp;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= 2'd0;
    else        phase <= (phase == 2'd1) ? 2'd2 : 2'd1;
  end

  assign ph1 = (phase == 2'd1);
  assign ph2 = (phase == 2'd2);

  assign in_tp = (state != S_STBY) && (state != S_PWR) &&
                 (state != S_WAIT) && (state != S_RLSE);

  always_comb begin
    if (cur == LAST && stby_req) begin
      succ_state = S_STBY;
      succ_cur   = cur;
    end else begin
      succ_cur   = (cur == LAST) ? 4'd0 : cur + 4'd1;
      succ_state = pulse_code(succ_cur);
    end
  end

  always_comb begin
    nxt_state = state;
    nxt_cur   = cur;
    case (state)
      S_STBY: if (!stby_req) nxt_state = S_PWR;
      S_PWR: begin
        nxt_state = pulse_code(4'd0);
        nxt_cur   = 4'd0;
      end
      S_WAIT: begin
        if (!step_mode) begin
          nxt_state = succ_state;
          nxt_cur   = succ_cur;
        end else if (step_btn) begin
          nxt_state = S_RLSE;
        end
      end
      S_RLSE: begin
        if (!step_btn) begin
          nxt_state = succ_state;
          nxt_cur   = succ_cur;
        end
      end
      default: begin
        if (step_mode) begin
          nxt_state = S_WAIT;
        end else begin
          nxt_state = succ_state;
          nxt_cur   = succ_cur;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_STBY;
      cur   <= LAST;
    end else if (ph1) begin
      state <= nxt_state;
      cur   <= nxt_cur;
    end
  end

  assign tp   = in_tp ? (12'd1 << cur) : 12'd0;
  assign busy = in_tp;

  a_r1_phases_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1 && ph2));
  a_r1_ph1_then_ph2: assert property (@(posedge clk) disable iff (!rst_n)
    ph1 |=> ph2);
  a_r1_ph2_then_ph1: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |=> ph1);
  a_r2_hold_off_ph1: assert property (@(posedge clk) disable iff (!rst_n)
    !ph1 |=> $stable(state));
  a_r3_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph1 && !step_mode && !(tp[11] && stby_req)) |=>
      ($countones(state ^ $past(state)) == 1));
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tp) && (busy == (tp != 12'd0)));
  a_r5_stby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STBY && stby_req) |=> (state == S_STBY));
  a_r8_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && step_mode && !step_btn) |=> (state == S_WAIT));
  a_r8_rlse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RLSE && step_btn) |=> (state == S_RLSE));
endmodule

// File: tb/test_tpg_sequencer.sv
module test_tpg_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_req = 1'b1;
  logic step_mode = 1'b0;
  logic step_btn = 1'b0;
  logic ph1, ph2, busy;
  logic [11:0] tp;
  logic [3:0] state;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam logic [3:0] ST_STBY = 4'b1111;
  localparam logic [3:0] ST_PWR  = 4'b1110;
  localparam logic [3:0] ST_WAIT = 4'b1010;
  localparam logic [3:0] ST_RLSE = 4'b1011;
  logic [3:0] gcode [12] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7,
                             4'h5, 4'h4, 4'hC, 4'hD, 4'h9, 4'h8};

  tpg_sequencer i_tpg_sequencer (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .step_mode(step_mode),
    .step_btn(step_btn), .ph1(ph1), .ph2(ph2), .tp(tp), .state(state),
    .busy(busy)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic advance();
    while (!ph1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_pulse(input string req, input int k);
    chk(req, int'(state), int'(gcode[k]));
    chk(req, int'(tp), 1 << k);
    chk(req, int'(busy), 1);
  endtask

  task automatic expect_idle(input string req, input logic [3:0] code);
    chk(req, int'(state), int'(code));
    chk(req, int'(tp), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset ph1", int'(ph1), 0);
    chk("R1 reset ph2", int'(ph2), 0);
    expect_idle("R5 reset stby", ST_STBY);
    rst_n = 1'b1;
  endtask

  task automatic t_phases();
    logic p1;
    @(negedge clk);
    chk("R1 first ph1", int'(ph1), 1);
    p1 = ph1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R1 disjoint", int'(ph1 & ph2), 0);
      chk("R1 alternate", int'(ph1), int'(!p1));
      p1 = ph1;
    end
    expect_idle("R5 stby held", ST_STBY);
  endtask

  task automatic t_startup();
    stby_req = 1'b0;
    advance();
    expect_idle("R5 power-on", ST_PWR);
    advance();
    expect_pulse("R5 first pulse", 0);
  endtask

  task automatic t_run();
    logic [3:0] prev;
    for (int i = 1; i <= 12; i++) begin
      prev = state;
      advance();
      expect_pulse("R6 run order", i % 12);
      chk("R3 one bit", $countones(state ^ prev), 1);
      @(negedge clk);
      chk("R2 stable at ph2", int'(state), int'(gcode[i % 12]));
    end
  endtask

  task automatic t_standby();
    advance(); advance();
    expect_pulse("R6 to pulse 3", 2);
    stby_req = 1'b1;
    for (int k = 3; k < 12; k++) begin
      advance();
      expect_pulse("R7 cycle completes", k);
    end
    advance();
    expect_idle("R7 enter stby", ST_STBY);
    repeat (3) begin
      advance();
      expect_idle("R5 stby hold", ST_STBY);
    end
    stby_req = 1'b0;
    advance();
    expect_idle("R5 power-on again", ST_PWR);
    advance();
    expect_pulse("R5 restart", 0);
  endtask

  task automatic t_step();
    step_mode = 1'b1;
    for (int k = 1; k <= 2; k++) begin
      advance();
      expect_idle("R8 wait", ST_WAIT);
      repeat (2) begin
        advance();
        expect_idle("R8 wait hold", ST_WAIT);
      end
      step_btn = 1'b1;
      advance();
      expect_idle("R8 release", ST_RLSE);
      repeat (2) begin
        advance();
        expect_idle("R8 release hold", ST_RLSE);
      end
      step_btn = 1'b0;
      advance();
      expect_pulse("R8 one step", k);
    end
  endtask

  task automatic t_leave_step();
    advance();
    expect_idle("R9 wait", ST_WAIT);
    step_mode = 1'b0;
    advance();
    expect_pulse("R9 leave wait", 3);
    advance();
    expect_pulse("R9 run again", 4);
  endtask

  initial begin
    t_reset();
    t_phases();
    t_startup();
    t_run();
    t_standby();
    t_step();
    t_leave_step();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule